// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block holds the per-interrupt state of a multi-CPU interrupt distributor and makes it reachable through a simple 32-bit word register bus. It covers `NUM_IRQS` interrupt lines, 128 by default. IDs 0 to 15 are software-generated and IDs 16 to 31 are per-CPU peripheral lines. These 32 private lines are held in a separate copy for each CPU. IDs 32 and above are shared by all CPUs and exist once. For every line the bank stores an enable bit, a pending bit and a trigger-type bit (level or edge).

Software changes the enable and pending bitmaps through paired set and clear windows, so it never needs a read-modify-write. Each bus request carries the ID of the CPU that issues it. Accesses to the private part of any bitmap are steered to that CPU's copy. Several ranges of the architectural map are hardwired to read as zero and to ignore writes.

Downstream priority and CPU-interface logic reads two flat vectors with one slot per (CPU, interrupt) pair:
- the lines that are enabled and pending, gated by a global enable;
- the trigger type of each line.

Top module: `irq_dist_regs`

## Requirements
- R1: After reset the global enable, every enable bit, every pending bit and every trigger bit are zero. `rsp_valid`, `irq_fire` and `trig_edge` are all zero.
- R2: Every request cycle (`req_valid`=1) is followed in the next cycle by exactly one cycle with `rsp_valid`=1. `rsp_valid` is 0 in a cycle that does not follow a request. A write response carries `rsp_rdata`=0. A read response returns the state as it stood before any write in the same cycle.
- R3: Enable-set words are at 0x100+4*w for w < NUM_IRQS/32, and bit b controls ID 32*w+b. Writing 1 to a bit sets that enable, and writing 0 leaves it unchanged. Reading the word returns the current enables.
- R4: Enable-clear words are at 0x180+4*w with the same bit layout. Writing 1 clears that enable, and writing 0 leaves it unchanged. Reading the word returns the current enables.
- R5: Pending state uses the same scheme: the set words are at 0x200+4*w and the clear words are at 0x280+4*w. Both read back the current pending bits.
- R6: Word 0 of the enable, pending and trigger maps (IDs 0 to 31) reads and writes the copy selected by `req_cpu`. Words for IDs 32 and above act on one copy shared by all CPUs.
- R7: Trigger words are at 0xC00+4*k for k < NUM_IRQS/16. ID 16*k+j uses bits [2j+1:2j]. Bit 2j+1 set to 1 selects edge and 0 selects level. Bit 2j always reads 0. The stored value appears on `trig_edge`.
- R8: All of the following read as 0 and ignore writes:
  - the group range 0x080 to 0x0FF;
  - the active ranges 0x300 to 0x3FF;
  - bitmap or trigger words beyond the interrupt count;
  - offsets 0x00C to 0x07F;
  - every other offset not listed in R3 to R7 and R9.
- R9: Offset 0x000 holds the global enable in bit 0, and it reads back. Offset 0x004 is read-only and returns bits [4:0] = NUM_IRQS/32-1 and bits [7:5] = NUM_CPUS-1, with the upper bits 0. Offset 0x008 is read-only and returns the `IDENT` parameter.
- R10: `irq_fire[c*NUM_IRQS+i]` equals global enable AND enable AND pending of ID i as seen by CPU c. It reflects a write from the cycle after the write is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cpu | input | CPU_W | ID of the requesting CPU; selects the private copy |
| req_addr | input | 12 | Byte offset; bits [1:0] are ignored |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_rdata | output | 32 | Read data; 0 for writes |
| irq_fire | output | NUM_CPUS*NUM_IRQS | Enabled-and-pending lines per CPU |
| trig_edge | output | NUM_CPUS*NUM_IRQS | Edge-trigger selection per CPU and line |

## Verification
A wrong bit in the enable or pending state shows up on `irq_fire` in the cycle after the faulty write. It also appears on the read data of the next read of that word, one cycle after that read is issued. Banking faults only become visible when a second CPU reads the same private word, so the stimulus switches `req_cpu` between accesses. Any of these faults shows up on the first access that crosses banks, which catches faults such as a shared word that is not broadcast or a private word that leaks into another copy. A decode fault in a read-as-zero or write-ignored range shows either as nonzero read data or as a change to `irq_fire` or `trig_edge` after the ignored write.

// File: rtl/irq_dist_regs.sv
module irq_dist_regs #(
  parameter int NUM_IRQS = 128,
  parameter int NUM_CPUS = 8,
  parameter logic [31:0] IDENT = 32'h0020_0101,
  localparam int CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int NFIRE = NUM_CPUS * NUM_IRQS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [CPU_W-1:0] req_cpu,
  input  logic [11:0]      req_addr,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  output logic [31:0]      rsp_rdata,
  output logic [NFIRE-1:0] irq_fire,
  output logic [NFIRE-1:0] trig_edge
);

  localparam int NWORDS = NUM_IRQS / 32;
  localparam int SWORDS = NWORDS - 1;
  localparam int CWORDS = NUM_IRQS / 16;
  localparam logic [31:0] TYPE_WORD = {24'b0, 3'(NUM_CPUS - 1), 5'(NWORDS - 1)};

  logic                                glb_en;
  logic [NUM_CPUS-1:0][31:0]           p_en, p_pd;
  logic [SWORDS-1:0][31:0]             s_en, s_pd;
  logic [NUM_CPUS-1:0][1:0][15:0]      p_edge;
  logic [CWORDS-3:0][15:0]             s_edge;
  logic [NUM_CPUS-1:0]                 cpu_hit;
  logic [31:0]                         rd;

  wire [4:0] rgn = req_addr[11:7];
  wire [4:0] bw  = req_addr[6:2];
  wire [5:0] cw  = req_addr[7:2];
  wire [31:0] wd = req_wdata;
  wire wr     = req_valid && req_write;
  wire clr    = rgn[0];
  wire en_acc = (rgn == 5'd2 || rgn == 5'd3) && (32'(bw) < NWORDS);
  wire pd_acc = (rgn == 5'd4 || rgn == 5'd5) && (32'(bw) < NWORDS);
  wire cf_acc = (req_addr[11:8] == 4'hC) && (32'(cw) < CWORDS);

  function automatic logic [15:0] odd_bits(input logic [31:0] v);
    for (int b = 0; b < 16; b++) odd_bits[b] = v[2*b+1];
  endfunction

  function automatic logic [31:0] spread(input logic [15:0] v);
    spread = '0;
    for (int b = 0; b < 16; b++) spread[2*b+1] = v[b];
  endfunction

  function automatic logic [31:0] upd(input logic [31:0] old, input logic [31:0] d,
                                      input logic c);
    upd = c ? (old & ~d) : (old | d);
  endfunction

  always_comb
    for (int c = 0; c < NUM_CPUS; c++) cpu_hit[c] = (32'(req_cpu) == c);

  always_comb begin
    rd = '0;
    if (req_addr[11:2] == 10'd0)      rd = {31'b0, glb_en};
    else if (req_addr[11:2] == 10'd1) rd = TYPE_WORD;
    else if (req_addr[11:2] == 10'd2) rd = IDENT;
    else if (en_acc || pd_acc) begin
      for (int c = 0; c < NUM_CPUS; c++)
        if (cpu_hit[c] && bw == 5'd0) rd = en_acc ? p_en[c] : p_pd[c];
      for (int j = 0; j < SWORDS; j++)
        if (32'(bw) == j + 1) rd = en_acc ? s_en[j] : s_pd[j];
    end else if (cf_acc) begin
      for (int c = 0; c < NUM_CPUS; c++)
        if (cpu_hit[c] && cw < 6'd2) rd = spread(p_edge[c][cw[0]]);
      for (int k = 0; k < CWORDS - 2; k++)
        if (32'(cw) == k + 2) rd = spread(s_edge[k]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_en <= 1'b0;
      p_en   <= '0;
      p_pd   <= '0;
      s_en   <= '0;
      s_pd   <= '0;
      p_edge <= '0;
      s_edge <= '0;
    end else if (wr) begin
      if (req_addr[11:2] == 10'd0) glb_en <= wd[0];
      for (int c = 0; c < NUM_CPUS; c++) begin
        if (cpu_hit[c]) begin
          if (en_acc && bw == 5'd0) p_en[c] <= upd(p_en[c], wd, clr);
          if (pd_acc && bw == 5'd0) p_pd[c] <= upd(p_pd[c], wd, clr);
          if (cf_acc && cw < 6'd2) p_edge[c][cw[0]] <= odd_bits(wd);
        end
      end
      for (int j = 0; j < SWORDS; j++) begin
        if (32'(bw) == j + 1) begin
          if (en_acc) s_en[j] <= upd(s_en[j], wd, clr);
          if (pd_acc) s_pd[j] <= upd(s_pd[j], wd, clr);
        end
      end
      for (int k = 0; k < CWORDS - 2; k++)
        if (cf_acc && 32'(cw) == k + 2) s_edge[k] <= odd_bits(wd);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= (req_valid && !req_write) ? rd : 32'd0;
    end
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_view
    assign irq_fire[c*NUM_IRQS +: NUM_IRQS] =
      {s_en, p_en[c]} & {s_pd, p_pd[c]} & {NUM_IRQS{glb_en}};
    assign trig_edge[c*NUM_IRQS +: NUM_IRQS] = {s_edge, p_edge[c]};
  end

endmodule

module irq_dist_regs_chk #(
  parameter int NUM_IRQS = 128,
  parameter int NUM_CPUS = 8,
  localparam int NFIRE = NUM_CPUS * NUM_IRQS
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic [11:0]      req_addr,
  input logic [31:0]      req_wdata,
  input logic             rsp_valid,
  input logic [31:0]      rsp_rdata,
  input logic [NFIRE-1:0] irq_fire
);

  // R2
  resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R2
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R2
  write_resp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> rsp_rdata == 32'd0);

  // R8
  raz_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write &&
     (req_addr[11:7] == 5'd1 || req_addr[11:7] == 5'd6 || req_addr[11:7] == 5'd7))
    |=> rsp_rdata == 32'd0);

  // R9
  type_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == 12'h004)
    |=> rsp_rdata == {24'b0, 3'(NUM_CPUS - 1), 5'(NUM_IRQS / 32 - 1)});

  // R10
  global_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 12'h000 && !req_wdata[0])
    |=> irq_fire == '0);

  // R4
  enable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 12'h184 && req_wdata == 32'hFFFF_FFFF)
    |=> irq_fire[63:32] == 32'd0);

endmodule

bind irq_dist_regs irq_dist_regs_chk #(.NUM_IRQS(NUM_IRQS), .NUM_CPUS(NUM_CPUS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .irq_fire(irq_fire)
);

// File: tb/test_irq_dist_regs.sv
module test_irq_dist_regs;
  localparam int NI = 128;
  localparam int NC = 8;
  localparam logic [31:0] ID_VAL = 32'h0020_0101;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [2:0] req_cpu = 0;
  logic [11:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NC*NI-1:0] irq_fire, trig_edge;

  irq_dist_regs #(.NUM_IRQS(NI), .NUM_CPUS(NC), .IDENT(ID_VAL)) i_irq_dist_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_cpu(req_cpu), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq_fire(irq_fire),
    .trig_edge(trig_edge));

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;
  bit m_glb;
  bit m_en [NC][NI];
  bit m_pd [NC][NI];
  bit m_edge [NC][NI];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(int cpu, logic [11:0] a);
    logic [31:0] r = '0;
    int rg = int'(a[11:7]);
    int w = int'(a[6:2]);
    int cw = int'(a[7:2]);
    if (a[11:2] == 0) r[0] = m_glb;
    else if (a[11:2] == 1) r = {24'b0, 3'(NC - 1), 5'(NI / 32 - 1)};
    else if (a[11:2] == 2) r = ID_VAL;
    else if (rg >= 2 && rg <= 5 && w < NI / 32) begin
      for (int b = 0; b < 32; b++)
        r[b] = (rg < 4) ? m_en[cpu][32*w+b] : m_pd[cpu][32*w+b];
    end else if (a[11:8] == 4'hC && cw < NI / 16) begin
      for (int b = 0; b < 16; b++) r[2*b+1] = m_edge[cpu][16*cw+b];
    end
    return r;
  endfunction

  function automatic void apply_write(int cpu, logic [11:0] a, logic [31:0] d);
    int rg = int'(a[11:7]);
    int w = int'(a[6:2]);
    int cw = int'(a[7:2]);
    if (a[11:2] == 0) m_glb = d[0];
    else if (rg >= 2 && rg <= 5 && w < NI / 32) begin
      for (int b = 0; b < 32; b++) begin
        int id = 32 * w + b;
        if (d[b])
          for (int c = 0; c < NC; c++)
            if (id >= 32 || c == cpu) begin
              if (rg < 4) m_en[c][id] = (rg == 2);
              else        m_pd[c][id] = (rg == 4);
            end
      end
    end else if (a[11:8] == 4'hC && cw < NI / 16) begin
      for (int b = 0; b < 16; b++) begin
        int id = 16 * cw + b;
        for (int c = 0; c < NC; c++)
          if (id >= 32 || c == cpu) m_edge[c][id] = d[2*b+1];
      end
    end
  endfunction

  function automatic logic [NC*NI-1:0] exp_fire();
    logic [NC*NI-1:0] v;
    for (int c = 0; c < NC; c++)
      for (int i = 0; i < NI; i++) v[c*NI+i] = m_glb & m_en[c][i] & m_pd[c][i];
    return v;
  endfunction

  function automatic logic [NC*NI-1:0] exp_edge();
    logic [NC*NI-1:0] v;
    for (int c = 0; c < NC; c++)
      for (int i = 0; i < NI; i++) v[c*NI+i] = m_edge[c][i];
    return v;
  endfunction

  function automatic string tag_of(logic [11:0] a);
    case (a[11:7])
      5'd0: return (a[11:2] < 3) ? "R9" : "R8";
      5'd2: return "R3";
      5'd3: return "R4";
      5'd4, 5'd5: return "R5";
      default: return (a[11:8] == 4'hC) ? "R7" : "R8";
    endcase
  endfunction

  task automatic check_views(string tag);
    logic [NC*NI-1:0] ef = exp_fire();
    logic [NC*NI-1:0] ee = exp_edge();
    tests++;
    if (irq_fire !== ef) begin
      fails++;
      $display("FAIL R10 (%s): irq_fire got %h expected %h", tag, irq_fire, ef);
    end
    tests++;
    if (trig_edge !== ee) begin
      fails++;
      $display("FAIL R7 (%s): trig_edge got %h expected %h", tag, trig_edge, ee);
    end
  endtask

  task automatic access(bit w, int cpu, logic [11:0] a, logic [31:0] d, string tag);
    logic [31:0] e = w ? 32'd0 : exp_read(cpu, a);
    @(negedge clk);
    req_valid = 1; req_write = w; req_cpu = 3'(cpu); req_addr = a; req_wdata = d;
    @(negedge clk);
    chk("R2", {31'b0, rsp_valid}, 32'd1);
    chk(tag, rsp_rdata, e);
    req_valid = 0;
    if (w) apply_write(cpu, a, d);
    check_views(tag);
    @(negedge clk);
    chk("R2", {31'b0, rsp_valid}, 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_glb = 0;
    for (int c = 0; c < NC; c++)
      for (int i = 0; i < NI; i++) begin m_en[c][i] = 0; m_pd[c][i] = 0; m_edge[c][i] = 0; end
    repeat (3) @(negedge clk);
    chk("R1", {31'b0, rsp_valid}, 32'd0);
    check_views("R1");
    rst_n = 1;
    access(0, 3, 12'h100, 0, "R1");
    access(0, 0, 12'h000, 0, "R1");
    access(0, 1, 12'h004, 0, "R9");
    access(0, 1, 12'h008, 0, "R9");
    access(1, 1, 12'h004, 32'hFFFF_FFFF, "R9");
    access(0, 1, 12'h004, 0, "R9");
    access(1, 0, 12'h000, 32'h1, "R9");
    access(0, 6, 12'h000, 0, "R9");
    access(1, 2, 12'h100, 32'h0000_00F0, "R6");
    access(0, 5, 12'h100, 0, "R6");
    access(0, 2, 12'h180, 0, "R6");
    access(1, 2, 12'h104, 32'h0000_0001, "R6");
    access(0, 5, 12'h104, 0, "R6");
    access(1, 2, 12'h200, 32'h0000_0010, "R5");
    access(1, 7, 12'h204, 32'h0000_0001, "R5");
    access(1, 2, 12'h100, 32'h0, "R3");
    access(0, 2, 12'h100, 0, "R3");
    access(1, 4, 12'h184, 32'hFFFF_FFFF, "R4");
    access(0, 4, 12'h104, 0, "R4");
    access(1, 2, 12'h280, 32'h0, "R5");
    access(0, 2, 12'h200, 0, "R5");
    access(1, 3, 12'hC08, 32'hFFFF_FFFF, "R7");
    access(0, 0, 12'hC08, 0, "R7");
    access(1, 3, 12'hC00, 32'h5555_AAAA, "R7");
    access(0, 3, 12'hC00, 0, "R7");
    access(0, 4, 12'hC00, 0, "R7");
    access(1, 1, 12'h080, 32'hFFFF_FFFF, "R8");
    access(0, 1, 12'h080, 0, "R8");
    access(1, 1, 12'h300, 32'hFFFF_FFFF, "R8");
    access(0, 1, 12'h380, 0, "R8");
    access(1, 1, 12'h110, 32'hFFFF_FFFF, "R8");
    access(0, 1, 12'h110, 0, "R8");
    access(0, 1, 12'h00C, 0, "R8");
    access(1, 1, 12'hC20, 32'hFFFF_FFFF, "R8");
    access(0, 1, 12'hC20, 0, "R8");
    access(1, 0, 12'h000, 32'h0, "R10");
    access(1, 0, 12'h000, 32'h1, "R10");

    for (int n = 0; n < 3000; n++) begin
      int kind = $urandom_range(0, 7);
      int cpu = $urandom_range(0, NC - 1);
      bit w = $urandom_range(0, 1) == 1;
      logic [31:0] d = $urandom;
      logic [11:0] a;
      case (kind)
        0: begin a = 12'h000; d = {31'b0, ($urandom_range(0, 3) != 0)}; end
        1: a = 12'h100 + 12'(4 * $urandom_range(0, 5));
        2: begin a = 12'h180 + 12'(4 * $urandom_range(0, 5)); d = d & $urandom & $urandom; end
        3: a = 12'h200 + 12'(4 * $urandom_range(0, 5));
        4: begin a = 12'h280 + 12'(4 * $urandom_range(0, 5)); d = d & $urandom & $urandom; end
        5: a = 12'hC00 + 12'(4 * $urandom_range(0, 9));
        6: begin
          int r = $urandom_range(0, 2);
          a = (r == 0) ? 12'h080 : (r == 1) ? 12'h300 : 12'h380;
          a = a + 12'(4 * $urandom_range(0, 31));
        end
        default: a = 12'(($urandom_range(12'h400, 12'hBFF)) & 12'hFFC);
      endcase
      access(w, cpu, a, d, tag_of(a));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule